// File: doc/BRIEF.md
# Folded single-port SRAM array controller

This block is a synthesizable behavioural model of a single-ported memory holding 2048 words of 16 bits. The words are stored in a physical array that is folded into 256 rows of 128 bit-columns. An incoming 11-bit address is split into a row field and a column field. The row field is decoded into one-hot wordlines by a two-level decoder built from 2-bit predecoders. The column field steers sixteen 8:1 column multiplexers, each of which picks one bit out of its own group of eight adjacent columns.

Every access runs through three fixed phases of one clock each:
- Conditioning: bitline precharge for a read, or driving the bitlines for a write.
- Wordline: exactly one wordline is raised.
- Sense: the read value is resolved.

The strobes for the three phases are brought out as ports so that a checker can watch them. Read data is registered and is marked by a one-cycle valid pulse. A write takes priority over a read requested in the same cycle. While an access is running, the block reports busy and ignores new requests.

Top module: `sram_fold_top`

## Requirements
- R1: While reset is low and in the first cycle after it, `busy`, `rvalid`, `precharge`, `bl_drive`, `sense_en` and every wordline are 0.
- R2: A read from an address returns the 16-bit word most recently written to that address.
- R3: Address bits [2:0] pick the column inside each 8-column group, and bits [10:3] pick the row. Output bit i is taken from physical column i*8+addr[2:0], so the eight addresses that share a row hold independent words.
- R4: In the first cycle after a request is accepted, `precharge` is 1 for a read and `bl_drive` is 1 for a write. In that cycle the other of these two strobes is 0 and no wordline is active.
- R5: In the second cycle of an access, exactly one wordline is active, the one with index addr[10:3]. In every other cycle no wordline is active.
- R6: `sense_en` is 1 only in the third cycle of a read access, one phase after the wordline has been raised. It stays 0 during writes.
- R7: `busy` is 1 for the three phase cycles of an access and 0 otherwise. A read or write request presented while `busy` is 1 has no effect on the stored data and starts no access.
- R8: One cycle after the sense phase of a read, `rvalid` is 1 for exactly one cycle and `rdata` carries the word that was read. A write never raises `rvalid`.
- R9: When `req_rd` and `req_wr` are both 1 in the accepting cycle, only the write is performed: `bl_drive` rises, the word is stored, and no `rvalid` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_rd | input | 1 | Read request |
| req_wr | input | 1 | Write request; wins over a read in the same cycle |
| addr | input | 11 | Word address: [10:3] row, [2:0] column in group |
| wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress; requests ignored |
| rdata | output | 16 | Registered read data |
| rvalid | output | 1 | One-cycle qualifier for `rdata` |
| precharge | output | 1 | Conditioning strobe for reads |
| bl_drive | output | 1 | Conditioning strobe for writes |
| wordline | output | 256 | One-hot row select during the wordline phase |
| sense_en | output | 1 | Sense strobe for reads |

## Verification
Two functions can fall in the same cycle: request arbitration and the access that is already running. A request can be presented while another access is in flight, and a read and a write can be requested together. To provoke the first case, the bench drives a write of the inverted expected word to the same address during the conditioning and wordline cycles of an access. A later read then shows that the stored word is unchanged, and `busy` is checked to stay low once the access ends. To provoke the second case, both requests are raised at once. The outcome is judged by `bl_drive` rising, by the absence of `rvalid`, and by the new word being read back.

// File: rtl/sram_fold_pkg.sv
// Shared parameters and phase type for the folded SRAM controller.
// Assumes the row field width is a multiple of the predecoder slice width.
package sram_fold_pkg;
    localparam int ADDR_W     = 11;
    localparam int DATA_W     = 16;
    localparam int COL_SEL_W  = 3;
    localparam int ROW_W      = ADDR_W - COL_SEL_W;
    localparam int PRE_BITS   = 2;
    localparam int MUX_WAYS   = 1 << COL_SEL_W;
    localparam int ROWS       = 1 << ROW_W;
    localparam int COLS       = DATA_W * MUX_WAYS;
    localparam int PRE_GROUPS = ROW_W / PRE_BITS;
    localparam int PRE_LINES  = 1 << PRE_BITS;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_COND  = 2'd1,
        PH_WORD  = 2'd2,
        PH_SENSE = 2'd3
    } phase_t;
endpackage

// File: rtl/row_predecoder.sv
// Turns one address slice into a group of one-hot predecoded lines.
// All lines stay low while the enable is low.
module row_predecoder #(
    parameter int SEL_W = 2,
    localparam int LINES = 1 << SEL_W
) (
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic [LINES-1:0] lines
);
    // Raise the single line named by the slice when enabled.
    always_comb begin
        lines = '0;
        if (en) lines[sel] = 1'b1;
    end

    // R5: an enabled group has exactly one hot line, a disabled one none.
    always_comb begin
        p_pre_onehot_r5: assert (en ? $onehot(lines) : (lines == '0))
            else $error("predecoder group not one-hot");
    end
endmodule

// File: rtl/wordline_decoder.sv
// Two-level row decoder: predecoders on each address slice, then one
// AND of one line per group for every wordline.
// Assumes ROW_W is a multiple of PRE_BITS.
module wordline_decoder #(
    parameter int ROW_W    = 8,
    parameter int PRE_BITS = 2,
    localparam int ROWS       = 1 << ROW_W,
    localparam int PRE_GROUPS = ROW_W / PRE_BITS,
    localparam int PRE_LINES  = 1 << PRE_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [ROW_W-1:0] row,
    output logic [ROWS-1:0]  wordline
);
    logic [PRE_GROUPS*PRE_LINES-1:0] pre_flat;

    // One predecoder per address slice.
    for (genvar g = 0; g < PRE_GROUPS; g++) begin : g_pre
        row_predecoder #(.SEL_W(PRE_BITS)) pre_i (
            .en   (en),
            .sel  (row[g*PRE_BITS +: PRE_BITS]),
            .lines(pre_flat[g*PRE_LINES +: PRE_LINES])
        );
    end

    // Each wordline ANDs the matching line from every group.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [PRE_GROUPS-1:0] term;
        for (genvar g = 0; g < PRE_GROUPS; g++) begin : g_term
            assign term[g] = pre_flat[g*PRE_LINES + ((r >> (g*PRE_BITS)) % PRE_LINES)];
        end
        assign wordline[r] = &term;
    end

    // R5: never two wordlines at once.
    p_wl_onehot0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wordline));
    // R5: an enabled decoder raises exactly one wordline.
    p_wl_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> ($countones(wordline) == 1));
endmodule

// File: rtl/column_mux.sv
// Parallel column multiplexers: output bit i picks one column of group i.
// Columns of group i are contiguous: i*WAYS .. i*WAYS+WAYS-1.
module column_mux #(
    parameter int DATA_W = 16,
    parameter int SEL_W  = 3,
    localparam int WAYS = 1 << SEL_W,
    localparam int COLS = DATA_W * WAYS
) (
    input  logic [COLS-1:0]   row_bits,
    input  logic [SEL_W-1:0]  sel,
    output logic [DATA_W-1:0] dout
);
    // One WAYS:1 selector per output bit.
    for (genvar i = 0; i < DATA_W; i++) begin : g_mux
        logic [WAYS-1:0] group;
        assign group   = row_bits[i*WAYS +: WAYS];
        assign dout[i] = group[sel];
    end
endmodule

// File: rtl/access_sequencer.sv
// Steps each accepted request through conditioning, wordline and sense
// phases, one clock each. Accepts only when idle; write wins over read.
module access_sequencer
    import sram_fold_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_rd,
    input  logic   req_wr,
    output phase_t phase,
    output logic   op_write,
    output logic   start,
    output logic   busy
);
    assign busy  = (phase != PH_IDLE);
    assign start = !busy && (req_rd || req_wr);

    // Advance the phase and latch the operation kind on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            op_write <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE:  if (start) begin
                              phase    <= PH_COND;
                              op_write <= req_wr;
                          end
                PH_COND:  phase <= PH_WORD;
                PH_WORD:  phase <= PH_SENSE;
                PH_SENSE: phase <= PH_IDLE;
                default:  phase <= PH_IDLE;
            endcase
        end
    end

    // R4: a request seen while idle starts conditioning next cycle.
    p_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && (req_rd || req_wr)) |=> (phase == PH_COND));
    // R5: conditioning is always followed by the wordline phase.
    p_cond_to_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_COND) |=> (phase == PH_WORD));
    // R6: sense follows the wordline phase.
    p_word_to_sense_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WORD) |=> (phase == PH_SENSE));
    // R7: an access ends after sense, whatever is requested.
    p_sense_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SENSE) |=> (phase == PH_IDLE));
    // R7: requests during busy never restart conditioning.
    p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (phase != PH_COND));
endmodule

// File: rtl/sram_fold_top.sv
// Folded single-port SRAM: 2^ADDR_W words of DATA_W bits stored as
// ROWS rows of COLS columns. Addr low bits pick the column in a group,
// high bits the row. Storage has no reset; control is reset synchronously.
module sram_fold_top
    import sram_fold_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              precharge,
    output logic              bl_drive,
    output logic [ROWS-1:0]   wordline,
    output logic              sense_en
);
    phase_t               phase;
    logic                 op_write;
    logic                 start;
    logic [ROW_W-1:0]     row_q;
    logic [COL_SEL_W-1:0] col_q;
    logic [DATA_W-1:0]    wdata_q;
    logic [COLS-1:0]      array_q [ROWS];
    logic [DATA_W-1:0]    sensed;

    access_sequencer seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_rd  (req_rd),
        .req_wr  (req_wr),
        .phase   (phase),
        .op_write(op_write),
        .start   (start),
        .busy    (busy)
    );

    wordline_decoder #(.ROW_W(ROW_W), .PRE_BITS(PRE_BITS)) dec_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (phase == PH_WORD),
        .row     (row_q),
        .wordline(wordline)
    );

    column_mux #(.DATA_W(DATA_W), .SEL_W(COL_SEL_W)) mux_i (
        .row_bits(array_q[row_q]),
        .sel     (col_q),
        .dout    (sensed)
    );

    assign precharge = (phase == PH_COND) && !op_write;
    assign bl_drive  = (phase == PH_COND) &&  op_write;
    assign sense_en  = (phase == PH_SENSE) && !op_write;

    // Capture address fields and write data when an access is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q   <= '0;
            col_q   <= '0;
            wdata_q <= '0;
        end else if (start) begin
            row_q   <= addr[ADDR_W-1:COL_SEL_W];
            col_q   <= addr[COL_SEL_W-1:0];
            wdata_q <= wdata;
        end
    end

    // Store each data bit into its group column during the wordline phase.
    always_ff @(posedge clk) begin
        if (phase == PH_WORD && op_write) begin
            for (int i = 0; i < DATA_W; i++) begin
                array_q[row_q][i*MUX_WAYS + int'(col_q)] <= wdata_q[i];
            end
        end
    end

    // Register sensed data and pulse the valid flag after a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= sense_en;
            if (sense_en) rdata <= sensed;
        end
    end

    // R4: no wordline while bitlines are being conditioned.
    p_no_wl_cond_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (precharge || bl_drive) |-> (wordline == '0));
    // R4: the two conditioning strobes never overlap.
    p_cond_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(precharge && bl_drive));
    // R6: sensing only one phase after a raised wordline.
    p_sense_after_wl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sense_en) |-> ($past(wordline) != '0));
    // R8: valid is a single-cycle pulse.
    p_rvalid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);
    // R9: simultaneous requests in idle start a write.
    p_wr_priority_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_rd && req_wr) |=> bl_drive);
endmodule

// File: tb/sram_fold_top_tb_top.sv
`timescale 1ns/1ps
module sram_fold_top_tb_top;
    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_rd, req_wr;
    logic [10:0]   addr;
    logic [15:0]   wdata;
    logic          busy, rvalid, precharge, bl_drive, sense_en;
    logic [15:0]   rdata;
    logic [255:0]  wordline;

    int checks = 0;
    int errors = 0;
    logic [15:0] ref_mem [2048];

    always #10 clk = ~clk;

    sram_fold_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr),
        .addr(addr), .wdata(wdata), .busy(busy), .rdata(rdata),
        .rvalid(rvalid), .precharge(precharge), .bl_drive(bl_drive),
        .wordline(wordline), .sense_en(sense_en)
    );

    task automatic chk(input logic [255:0] act, input logic [255:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [255:0] exp_wl(input logic [10:0] a);
        logic [255:0] v = '0;
        v[a[10:3]] = 1'b1;
        return v;
    endfunction

    // Pool of 64 addresses: rows 0..3 and 252..255, all eight columns.
    function automatic logic [10:0] pool_addr(input int idx);
        int grp = (idx >> 3) & 7;
        logic [7:0] row = (grp < 4) ? 8'(grp) : 8'(248 + grp);
        return {row, 3'(idx & 7)};
    endfunction

    // One full access with per-phase checks; poke drives a write while busy.
    task automatic do_access(input bit rd, input bit wr, input logic [10:0] a,
                             input logic [15:0] d, input bit poke);
        bit is_w = wr;
        logic [15:0] exp_rd = ref_mem[a];
        @(negedge clk);
        req_rd = rd; req_wr = wr; addr = a; wdata = d;
        @(negedge clk);
        req_rd = 1'b0; req_wr = 1'b0;
        chk(busy, 1, "R7 busy in conditioning");
        chk(precharge, !is_w, "R4 precharge");
        chk(bl_drive, is_w, "R4/R9 bl_drive");
        chk(wordline, '0, "R4 no wordline in conditioning");
        if (poke) begin
            req_wr = 1'b1; addr = a; wdata = ~(is_w ? d : exp_rd);
        end
        @(negedge clk);
        chk(wordline, exp_wl(a), "R5 wordline one-hot at row");
        chk(sense_en, 0, "R6 no sense in wordline phase");
        chk(busy, 1, "R7 busy in wordline phase");
        @(negedge clk);
        req_wr = 1'b0;
        chk(sense_en, !is_w, "R6 sense strobe");
        chk(wordline, '0, "R5 wordline low in sense");
        @(negedge clk);
        chk(busy, 0, "R7 busy released");
        chk(rvalid, !is_w, "R8/R9 rvalid");
        if (!is_w) chk(rdata, exp_rd, "R2/R3 read data");
        @(negedge clk);
        chk(rvalid, 0, "R8 rvalid single pulse");
        chk(busy, 0, "R7 ignored request started nothing");
        if (is_w) ref_mem[a] = d;
    endtask

    initial begin
        fork
            begin
                repeat (200000) @(posedge clk);
                errors++;
                $display("FAIL watchdog actual=timeout expected=done");
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        join_none
    end

    initial begin
        void'($urandom(32'h5eed));
        rst_n = 1'b0; req_rd = 0; req_wr = 0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        chk({busy, rvalid, precharge, bl_drive, sense_en}, 0, "R1 strobes in reset");
        chk(wordline, '0, "R1 wordlines in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, rvalid, precharge, bl_drive, sense_en}, 0, "R1 strobes after reset");
        chk(wordline, '0, "R1 wordlines after reset");

        // R3: fill the pool; same-row neighbours get distinct words.
        for (int i = 0; i < 64; i++) do_access(0, 1, pool_addr(i), 16'(i * 16'h0491 + 16'h1f3c), 0);
        for (int i = 0; i < 64; i++) do_access(1, 0, pool_addr(i), 16'h0, 0);
        // R3: walking-one per column of row 0.
        for (int c = 0; c < 8; c++) do_access(0, 1, pool_addr(c), 16'(1 << (c * 2)), 0);
        for (int c = 0; c < 8; c++) do_access(1, 0, pool_addr(c), 16'h0, 0);
        // R9: read and write together.
        do_access(1, 1, pool_addr(63), 16'hA5C3, 0);
        do_access(1, 0, pool_addr(63), 16'h0, 0);
        // R7: writes poked during busy must not land.
        do_access(1, 0, pool_addr(9), 16'h0, 1);
        do_access(0, 1, pool_addr(10), 16'h7E81, 1);
        do_access(1, 0, pool_addr(9), 16'h0, 0);
        do_access(1, 0, pool_addr(10), 16'h0, 0);
        // Random mix over the pool.
        for (int n = 0; n < 400; n++) begin
            int idx = int'($urandom_range(63));
            int kind = int'($urandom_range(9));
            logic [15:0] d = 16'($urandom);
            if (kind < 4)      do_access(0, 1, pool_addr(idx), d, 0);
            else if (kind < 8) do_access(1, 0, pool_addr(idx), d, 0);
            else if (kind < 9) do_access(1, 1, pool_addr(idx), d, 0);
            else               do_access(1, 0, pool_addr(idx), d, 1);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule